// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block decides, every clock, which of the decoded instructions offered at the front of an out-of-order core may enter the current dispatch group. Up to `LANES` instructions are presented in parallel, lane 0 being the oldest. Each carries a micro-op count and two grouping flags. The first flag, start-group, demands that the instruction open an empty group. The second, close-group, ends the group as soon as the instruction is taken. Per lane, the block raises a ready signal combinationally. A lane is dispatched on a clock edge where its valid and ready are both high.

The group has `DISPATCH_W` micro-op slots, refilled at every clock. Walking the lanes from oldest to youngest, a chain of lane slices hands down the remaining slot count. Each slice also passes on whether a close-group instruction has sealed the group and whether an older lane was left behind, since dispatch must stay in program order. Nothing is stored between cycles except the registered per-cycle statistics: the number of instructions taken, the micro-ops they carry, and a pulse marking cycles sealed by a close-group instruction.

Top module: `dispatch_group_alloc`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `disp_count`, `disp_uops` and `group_closed` are zero after each clock edge.
- R2: A lane needs min(micro-op count, DISPATCH_W) slots. With DISPATCH_W = 6, an instruction of 9 micro-ops is ready when the group still holds all 6 slots.
- R3: A lane is not ready when the slots it needs exceed the slots left after all older lanes that are taken.
- R4: A lane with `in_begin` set is ready only when the remaining slot count equals DISPATCH_W. This also holds after older zero-micro-op instructions.
- R5: When a lane with `in_end` set is taken, no younger lane is ready in that cycle. `group_closed` is high in the following cycle.
- R6: Taking a lane lowers the remaining slots by its full micro-op count, saturating at zero. A zero-micro-op instruction can still be taken when no slots remain.
- R7: A lane that is not taken, whether not valid or not ready, leaves every younger lane not ready in that cycle.
- R8: Slots refill each clock, so lane 0 is always ready whatever happened in earlier cycles.
- R9: One clock after a cycle, `disp_count` equals the number of lanes taken in it and `disp_uops` the sum of their micro-op counts.
- R10: A lane's ready does not depend on its own valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Per-lane instruction valid, lane 0 oldest |
| in_uops | input | LANES*UOP_W | Per-lane micro-op count, lane i at bits [i*UOP_W +: UOP_W] |
| in_begin | input | LANES | Per-lane start-group flag |
| in_end | input | LANES | Per-lane close-group flag |
| in_ready | output | LANES | Per-lane dispatch permission, combinational |
| disp_count | output | CNT_W | Instructions taken in the previous cycle |
| disp_uops | output | SUM_W | Micro-ops taken in the previous cycle |
| group_closed | output | 1 | Previous cycle was sealed by a close-group instruction |

## Verification
The hardest case to reach from the ports is a start-group instruction in a younger lane. It is legal there only when every older lane is valid, taken and carries zero micro-ops. A further twist is an oversized instruction meeting a group that still holds its full width. Directed vectors build these chains by hand. A long pseudo-random sweep then draws micro-op counts between 0 and 8 and sets the flags often, which produces many groups that mix zero-count lanes, saturation and sealing. A bench-side walk of the rules predicts every ready bit and statistic.

// File: rtl/dga_pkg.sv
package dga_pkg;
  parameter int unsigned DEF_DISPATCH_W = 6;
  parameter int unsigned DEF_LANES      = 4;
  parameter int unsigned DEF_UOP_W      = 4;

  // slots an instruction occupies: its micro-op count clipped to the width
  function automatic int unsigned need_slots(input int unsigned uops,
                                             input int unsigned width);
    return (uops > width) ? width : uops;
  endfunction

  // remaining slots after taking an instruction, never below zero
  function automatic int unsigned sat_sub(input int unsigned avail,
                                          input int unsigned uops);
    return (uops >= avail) ? 0 : avail - uops;
  endfunction
endpackage

// File: rtl/dga_lane.sv
module dga_lane
  import dga_pkg::*;
#(
  parameter int unsigned DISPATCH_W = DEF_DISPATCH_W,
  parameter int unsigned UOP_W      = DEF_UOP_W,
  localparam int unsigned SLOT_W    = $clog2(DISPATCH_W + 1)
) (
  input  logic [SLOT_W-1:0] avail_i,
  input  logic              sealed_i,
  input  logic              held_i,
  input  logic              valid,
  input  logic [UOP_W-1:0]  uops,
  input  logic              start_g,
  input  logic              close_g,
  output logic              ready,
  output logic              take,
  output logic [SLOT_W-1:0] avail_o,
  output logic              sealed_o,
  output logic              held_o
);
  int unsigned need;
  int unsigned have;
  int unsigned left;

  always_comb begin
    have  = 32'(avail_i);
    need  = need_slots(32'(uops), DISPATCH_W);
    ready = !held_i && !sealed_i && (need <= have) &&
            (!start_g || have == DISPATCH_W);
    take  = ready && valid;
    if (!take)        left = have;
    else if (close_g) left = 0;
    else              left = sat_sub(have, 32'(uops));
    avail_o  = SLOT_W'(left);
    sealed_o = sealed_i | (take & close_g);
    held_o   = held_i | ~take;
  end
endmodule

// File: rtl/dga_stats.sv
module dga_stats #(
  parameter int unsigned LANES = 4,
  parameter int unsigned UOP_W = 4,
  localparam int unsigned CNT_W = $clog2(LANES + 1),
  localparam int unsigned SUM_W = $clog2(LANES * ((1 << UOP_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       take,
  input  logic [LANES*UOP_W-1:0] uops,
  input  logic                   sealed,
  output logic [CNT_W-1:0]       disp_count,
  output logic [SUM_W-1:0]       disp_uops,
  output logic                   group_closed
);
  logic [CNT_W-1:0] cnt_n;
  logic [SUM_W-1:0] sum_n;

  always_comb begin
    cnt_n = '0;
    sum_n = '0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (take[i]) begin
        cnt_n = cnt_n + CNT_W'(1);
        sum_n = sum_n + SUM_W'(uops[i*UOP_W +: UOP_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_count   <= '0;
      disp_uops    <= '0;
      group_closed <= 1'b0;
    end else begin
      disp_count   <= cnt_n;
      disp_uops    <= sum_n;
      group_closed <= sealed;
    end
  end
endmodule

// File: rtl/dispatch_group_alloc.sv
module dispatch_group_alloc
  import dga_pkg::*;
#(
  parameter int unsigned DISPATCH_W = DEF_DISPATCH_W,
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned UOP_W      = DEF_UOP_W,
  localparam int unsigned SLOT_W    = $clog2(DISPATCH_W + 1),
  localparam int unsigned CNT_W     = $clog2(LANES + 1),
  localparam int unsigned SUM_W     = $clog2(LANES * ((1 << UOP_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES*UOP_W-1:0] in_uops,
  input  logic [LANES-1:0]       in_begin,
  input  logic [LANES-1:0]       in_end,
  output logic [LANES-1:0]       in_ready,
  output logic [CNT_W-1:0]       disp_count,
  output logic [SUM_W-1:0]       disp_uops,
  output logic                   group_closed
);
  logic [SLOT_W-1:0] avail_c [LANES+1];
  logic [LANES:0]    sealed_c;
  logic [LANES:0]    held_c;
  logic [LANES-1:0]  take;

  // every clock opens a fresh group with all slots free
  assign avail_c[0]  = SLOT_W'(DISPATCH_W);
  assign sealed_c[0] = 1'b0;
  assign held_c[0]   = 1'b0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dga_lane #(
      .DISPATCH_W(DISPATCH_W),
      .UOP_W     (UOP_W)
    ) u_lane (
      .avail_i (avail_c[g]),
      .sealed_i(sealed_c[g]),
      .held_i  (held_c[g]),
      .valid   (in_valid[g]),
      .uops    (in_uops[g*UOP_W +: UOP_W]),
      .start_g (in_begin[g]),
      .close_g (in_end[g]),
      .ready   (in_ready[g]),
      .take    (take[g]),
      .avail_o (avail_c[g+1]),
      .sealed_o(sealed_c[g+1]),
      .held_o  (held_c[g+1])
    );
  end

  dga_stats #(
    .LANES(LANES),
    .UOP_W(UOP_W)
  ) u_stats (
    .clk         (clk),
    .rst         (rst),
    .take        (take),
    .uops        (in_uops),
    .sealed      (sealed_c[LANES]),
    .disp_count  (disp_count),
    .disp_uops   (disp_uops),
    .group_closed(group_closed)
  );
endmodule

// File: rtl/dga_checker.sv
module dga_checker #(
  parameter int unsigned DISPATCH_W = 6,
  parameter int unsigned LANES      = 4,
  parameter int unsigned UOP_W      = 4,
  localparam int unsigned CNT_W     = $clog2(LANES + 1),
  localparam int unsigned SUM_W     = $clog2(LANES * ((1 << UOP_W) - 1) + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       in_valid,
  input logic [LANES*UOP_W-1:0] in_uops,
  input logic [LANES-1:0]       in_begin,
  input logic [LANES-1:0]       in_end,
  input logic [LANES-1:0]       in_ready,
  input logic [CNT_W-1:0]       disp_count,
  input logic [SUM_W-1:0]       disp_uops,
  input logic                   group_closed
);
  logic [LANES-1:0] acc;
  logic [CNT_W-1:0] acc_cnt;
  logic [SUM_W-1:0] acc_sum;
  logic             acc_end;
  int unsigned      need_sum;
  logic [SUM_W-1:0] older_sum [LANES];
  logic [LANES-1:0] older_end;
  logic             armed;

  assign acc = in_valid & in_ready;

  always_comb begin
    acc_cnt  = '0;
    acc_sum  = '0;
    acc_end  = 1'b0;
    need_sum = 0;
    for (int i = 0; i < int'(LANES); i++) begin
      older_sum[i] = acc_sum;
      older_end[i] = acc_end;
      if (acc[i]) begin
        acc_cnt  = acc_cnt + CNT_W'(1);
        acc_sum  = acc_sum + SUM_W'(in_uops[i*UOP_W +: UOP_W]);
        acc_end  = acc_end | in_end[i];
        need_sum = need_sum + ((32'(in_uops[i*UOP_W +: UOP_W]) > DISPATCH_W)
                               ? DISPATCH_W : 32'(in_uops[i*UOP_W +: UOP_W]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_LANE0_READY: assert property (@(posedge clk) disable iff (rst)
    in_ready[0]); // R8

  AST_SLOT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    need_sum <= DISPATCH_W); // R3

  AST_STAT_COUNT: assert property (@(posedge clk) disable iff (rst)
    armed |-> (disp_count == $past(acc_cnt) && disp_uops == $past(acc_sum))); // R9

  AST_SEAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (group_closed == $past(acc_end))); // R5

  for (genvar g = 1; g < LANES; g++) begin : g_chk
    AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
      in_ready[g] |-> (in_valid[g-1] && in_ready[g-1])); // R7

    AST_START_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (in_ready[g] && in_begin[g]) |-> (older_sum[g] == '0)); // R4

    AST_SEALED_STOP: assert property (@(posedge clk) disable iff (rst)
      older_end[g] |-> !in_ready[g]); // R5
  end
endmodule

bind dispatch_group_alloc dga_checker #(
  .DISPATCH_W(DISPATCH_W),
  .LANES     (LANES),
  .UOP_W     (UOP_W)
) u_dga_checker (.*);

// File: tb/test_dispatch_group_alloc.sv
`timescale 1ns/1ps
module test_dispatch_group_alloc;
  localparam int W = 6;
  localparam int L = 4;
  localparam int U = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [L-1:0]  in_valid = '0;
  logic [L*U-1:0] in_uops = '0;
  logic [L-1:0]  in_begin = '0;
  logic [L-1:0]  in_end = '0;
  logic [L-1:0]  in_ready;
  logic [2:0]    disp_count;
  logic [5:0]    disp_uops;
  logic          group_closed;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dispatch_group_alloc i_dispatch_group_alloc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_begin(in_begin), .in_end(in_end), .in_ready(in_ready),
    .disp_count(disp_count), .disp_uops(disp_uops), .group_closed(group_closed)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected outcome computed from the group rules
  task automatic predict(input logic [L-1:0] v, input logic [L*U-1:0] u,
                         input logic [L-1:0] b, input logic [L-1:0] e,
                         output logic [L-1:0] rdy, output int cnt,
                         output int sum, output int sealed);
    int avail = W;
    int blk = 0;
    sealed = 0; cnt = 0; sum = 0; rdy = '0;
    for (int i = 0; i < L; i++) begin
      int uo = int'(u[i*U +: U]);
      int need = (uo > W) ? W : uo;
      rdy[i] = (blk == 0) && (sealed == 0) && (need <= avail) &&
               (!b[i] || avail == W);
      if (rdy[i] && v[i]) begin
        cnt++; sum += uo;
        if (e[i]) begin sealed = 1; avail = 0; end
        else avail = (uo >= avail) ? 0 : avail - uo;
      end else blk = 1;
    end
  endtask

  // drive one vector, check ready now and statistics after the edge
  task automatic apply(input logic [L-1:0] v, input logic [L*U-1:0] u,
                       input logic [L-1:0] b, input logic [L-1:0] e,
                       input string req);
    logic [L-1:0] rdy;
    int cnt, sum, sealed;
    @(negedge clk);
    in_valid = v; in_uops = u; in_begin = b; in_end = e;
    #1;
    predict(v, u, b, e, rdy, cnt, sum, sealed);
    chk({req, " ready"}, int'(in_ready), int'(rdy));
    @(posedge clk); #1;
    chk("R9 count", int'(disp_count), cnt);
    chk("R9 uops", int'(disp_uops), sum);
    chk("R5 closed pulse", int'(group_closed), sealed);
  endtask

  function automatic logic [L*U-1:0] pk(input int a, input int b2,
                                        input int c, input int d);
    return {U'(d), U'(c), U'(b2), U'(a)};
  endfunction

  initial begin : watchdog
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] s;
    in_valid = '1; in_uops = pk(1, 1, 1, 1); in_end = 4'b0001;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", int'(disp_count), 0);
    chk("R1 uops in reset", int'(disp_uops), 0);
    chk("R1 closed in reset", int'(group_closed), 0);
    @(negedge clk); rst = 1'b0;

    apply(4'b1111, pk(9, 1, 1, 1), 4'b0000, 4'b0000, "R2 oversize first");
    chk("R2 lane0 oversize ready", int'(in_ready[0]), 1);
    apply(4'b1111, pk(0, 9, 1, 1), 4'b0000, 4'b0000, "R2 oversize after zero");
    chk("R2 lane1 oversize ready", int'(in_ready[1]), 1);
    apply(4'b1111, pk(4, 3, 1, 1), 4'b0000, 4'b0000, "R3 overflow");
    chk("R3 lane1 refused", int'(in_ready[1]), 0);
    apply(4'b1111, pk(1, 2, 1, 1), 4'b0010, 4'b0000, "R4 start after work");
    chk("R4 lane1 start refused", int'(in_ready[1]), 0);
    apply(4'b1111, pk(0, 0, 2, 1), 4'b0100, 4'b0000, "R4 start after zeros");
    chk("R4 lane2 start ready", int'(in_ready[2]), 1);
    apply(4'b1111, pk(1, 1, 1, 1), 4'b0000, 4'b0001, "R5 seal lane0");
    chk("R5 lane1 after seal", int'(in_ready[1]), 0);
    chk("R5 pulse high", int'(group_closed), 1);
    apply(4'b1111, pk(4, 2, 0, 1), 4'b0000, 4'b0000, "R6 saturate");
    chk("R6 zero-uop lane2 ready", int'(in_ready[2]), 1);
    chk("R6 lane3 refused", int'(in_ready[3]), 0);
    apply(4'b1101, pk(1, 1, 1, 1), 4'b0000, 4'b0000, "R7 gap");
    chk("R7 lane2 after invalid", int'(in_ready[2]), 0);
    apply(4'b0001, pk(6, 0, 0, 0), 4'b0001, 4'b0000, "R8 refill");
    chk("R8 lane0 full again", int'(in_ready[0]), 1);
    apply(4'b0000, pk(2, 2, 2, 2), 4'b0000, 4'b0000, "R10 idle");
    chk("R10 lane0 ready without valid", int'(in_ready[0]), 1);

    s = 32'h1234_5678;
    for (int k = 0; k < 6000; k++) begin
      logic [L-1:0] v, b, e;
      logic [L*U-1:0] u;
      for (int i = 0; i < L; i++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        v[i] = (s[2:0] != 3'd0);
        b[i] = (s[4:3] == 2'd0);
        e[i] = (s[6:5] == 2'd0);
        u[i*U +: U] = U'(s[15:8] % 9);
      end
      apply(v, u, b, e, "R2 R3 R4 R5 R6 R7 sweep");
    end

    @(negedge clk); rst = 1'b1; in_valid = '1; in_uops = pk(3, 3, 0, 0);
    @(posedge clk); #1;
    chk("R1 count after reset", int'(disp_count), 0);
    chk("R1 uops after reset", int'(disp_uops), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule